// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits in the receive path of a serial port, between the byte assembler and the receive FIFO. Every incoming byte comes with a strobe. The block compares the byte against four programmable key characters: two "on" keys and two "off" keys. When a byte matches an eligible key, the block sets a sticky interrupt flag. The byte itself always continues to the FIFO side unchanged, one cycle later.

Matching can be qualified by four general-purpose input pins. In that mode the pins must equal the upper nibble of the key, and only the lower nibble of the received byte is compared. When single-byte software flow control runs at the same time, the primary on/off keys serve as the XON and XOFF characters. They produce one-cycle pulses for the transmit side. Only the secondary keys can then raise the special-character flag.

Top module: `rx_spchr_detect`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are 0 after that edge.
- R2: `out_valid` equals `in_valid` from the previous cycle. When that strobe was high, `out_byte` equals the byte presented with it, whether or not the byte matched.
- R3: While `det_en` is 0, no byte sets `irq_flag`.
- R4: `key_sel[0]` admits `key_on1` and `key_on2` to matching, and `key_sel[1]` admits `key_off1` and `key_off2`. A key that is not admitted never sets `irq_flag`.
- R5: With `gpio_qual` at 0, a key matches when all 8 bits of the received byte equal the key.
- R6: With `gpio_qual` at 1, a key matches when `gpio_in` equals key bits [7:4] and received bits [3:0] equal key bits [3:0]. Received bits [7:4] are ignored.
- R7: With `swfc_en` at 1, `key_on1` and `key_off1` never set `irq_flag`. Only `key_on2` and `key_off2` can, still subject to R4.
- R8: With `swfc_en` at 1, a strobed byte equal to `key_on1` (or `key_off1`) over all 8 bits gives a one-cycle `xon_pulse` (or `xoff_pulse`) in the next cycle. This is independent of `det_en`, `key_sel` and `gpio_qual`. With `swfc_en` at 0, both pulses stay 0.
- R9: Once set, `irq_flag` stays at 1 until a cycle with `irq_clr` high. It reads 0 in the following cycle.
- R10: A special-character match in the same cycle as `irq_clr` leaves `irq_flag` at 1.
- R11: A cycle with `in_valid` low sets no flag and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received-byte strobe |
| in_byte | input | 8 | Received byte |
| key_on1 | input | 8 | Primary on key (XON under flow control) |
| key_on2 | input | 8 | Secondary on key |
| key_off1 | input | 8 | Primary off key (XOFF under flow control) |
| key_off2 | input | 8 | Secondary off key |
| det_en | input | 1 | Special-character detection enable |
| gpio_qual | input | 1 | Qualify matching with GPIO pins |
| swfc_en | input | 1 | Single-byte software flow control active |
| key_sel | input | 2 | Key group admission: bit 0 on keys, bit 1 off keys |
| gpio_in | input | 4 | General-purpose input pin states |
| irq_clr | input | 1 | Clear-on-read strobe for the flag |
| out_valid | output | 1 | Forwarded strobe toward the FIFO |
| out_byte | output | 8 | Forwarded byte toward the FIFO |
| irq_flag | output | 1 | Sticky special-character flag |
| xon_pulse | output | 1 | XON received pulse |
| xoff_pulse | output | 1 | XOFF received pulse |

## Verification
The properties assume that the key registers, mode bits and `gpio_in` are settled at the edge where a byte is strobed, and that `irq_clr` is a synchronous single-cycle read side effect. The bench changes configuration only on the falling edge, before the strobe it applies to. It also drives `irq_clr` high with every byte of the sweep, so the flag after each byte reflects that byte alone. Sticky behaviour and clear priority get their own directed sequences.

// File: rtl/spchr_pkg.sv
package spchr_pkg;

    localparam int unsigned NKEY = 4;

    typedef enum logic [1:0] {
        K_ON1  = 2'd0,
        K_ON2  = 2'd1,
        K_OFF1 = 2'd2,
        K_OFF2 = 2'd3
    } key_e;

    typedef struct packed {
        logic       det_en;
        logic       gpio_qual;
        logic       swfc_en;
        logic [1:0] sel;
    } det_mode_t;

    // A key is admitted by its group bit; under flow control the primary
    // key of each group is reserved for XON/XOFF.
    function automatic logic key_eligible(input int unsigned idx,
                                          input logic [1:0] sel,
                                          input logic swfc);
        logic grp;
        logic primary;
        grp     = (idx >= 2) ? sel[1] : sel[0];
        primary = (idx == int'(K_ON1)) || (idx == int'(K_OFF1));
        return grp && !(swfc && primary);
    endfunction

endpackage

// File: rtl/spchr_cmp.sv
module spchr_cmp #(
    parameter int unsigned DW = 8,
    parameter int unsigned GW = DW / 2
) (
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] key,
    input  logic [GW-1:0] gpio,
    input  logic          qual,
    output logic          full_hit,
    output logic          det_hit
);
    localparam int unsigned LW = DW - GW;

    logic lo_hit;
    logic pin_hit;

    always_comb begin
        full_hit = (rx_byte == key);
        lo_hit   = (rx_byte[LW-1:0] == key[LW-1:0]);
        pin_hit  = (gpio == key[DW-1:LW]);
        det_hit  = qual ? (lo_hit && pin_hit) : full_hit;
    end
endmodule

// File: rtl/spchr_elig.sv
module spchr_elig
    import spchr_pkg::*;
#(
    parameter int unsigned N = NKEY
) (
    input  logic [1:0]   sel,
    input  logic         swfc,
    output logic [N-1:0] mask
);
    for (genvar i = 0; i < N; i++) begin : g_key
        assign mask[i] = key_eligible(i, sel, swfc);
    end
endmodule

// File: rtl/spchr_flag.sv
module spchr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/rx_spchr_detect.sv
module rx_spchr_detect
    import spchr_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned GW = DW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic [DW-1:0] key_on1,
    input  logic [DW-1:0] key_on2,
    input  logic [DW-1:0] key_off1,
    input  logic [DW-1:0] key_off2,
    input  logic          det_en,
    input  logic          gpio_qual,
    input  logic          swfc_en,
    input  logic [1:0]    key_sel,
    input  logic [GW-1:0] gpio_in,
    input  logic          irq_clr,
    output logic          out_valid,
    output logic [DW-1:0] out_byte,
    output logic          irq_flag,
    output logic          xon_pulse,
    output logic          xoff_pulse
);
    det_mode_t          mode;
    logic [DW-1:0]      keys [NKEY];
    logic [NKEY-1:0]    full_hit;
    logic [NKEY-1:0]    det_hit;
    logic [NKEY-1:0]    elig;
    logic               spc_match;
    logic               xon_now;
    logic               xoff_now;

    always_comb begin
        mode.det_en    = det_en;
        mode.gpio_qual = gpio_qual;
        mode.swfc_en   = swfc_en;
        mode.sel       = key_sel;
        keys[K_ON1]    = key_on1;
        keys[K_ON2]    = key_on2;
        keys[K_OFF1]   = key_off1;
        keys[K_OFF2]   = key_off2;
    end

    for (genvar k = 0; k < NKEY; k++) begin : g_cmp
        spchr_cmp #(.DW(DW), .GW(GW)) u_cmp (
            .rx_byte (in_byte),
            .key     (keys[k]),
            .gpio    (gpio_in),
            .qual    (mode.gpio_qual),
            .full_hit(full_hit[k]),
            .det_hit (det_hit[k])
        );
    end

    spchr_elig #(.N(NKEY)) u_elig (
        .sel (mode.sel),
        .swfc(mode.swfc_en),
        .mask(elig)
    );

    always_comb begin
        spc_match = in_valid && mode.det_en && |(det_hit & elig);
        xon_now   = in_valid && mode.swfc_en && full_hit[K_ON1];
        xoff_now  = in_valid && mode.swfc_en && full_hit[K_OFF1];
    end

    spchr_flag u_flag (
        .clk (clk),
        .rst (rst),
        .set (spc_match),
        .clr (irq_clr),
        .flag(irq_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_byte   <= '0;
            xon_pulse  <= 1'b0;
            xoff_pulse <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            if (in_valid) out_byte <= in_byte;
            xon_pulse  <= xon_now;
            xoff_pulse <= xoff_now;
        end
    end
endmodule

// File: rtl/spchr_chk.sv
module spchr_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] in_byte,
    input logic          det_en,
    input logic          swfc_en,
    input logic          irq_clr,
    input logic          out_valid,
    input logic [DW-1:0] out_byte,
    input logic          irq_flag,
    input logic          xon_pulse,
    input logic          xoff_pulse
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid && !irq_flag && !xon_pulse && !xoff_pulse);

    a_r2_forward: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid && out_byte == $past(in_byte));

    a_r2_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        !det_en && !irq_flag |=> !irq_flag);

    a_r8_no_pulse_off: assert property (@(posedge clk) disable iff (rst)
        !swfc_en |=> !xon_pulse && !xoff_pulse);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_flag && !irq_clr |=> irq_flag);

    a_r11_idle_no_set: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !irq_flag |=> !irq_flag);

    a_r11_idle_no_pulse: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !xon_pulse && !xoff_pulse);
endmodule

bind rx_spchr_detect spchr_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .det_en    (det_en),
    .swfc_en   (swfc_en),
    .irq_clr   (irq_clr),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .irq_flag  (irq_flag),
    .xon_pulse (xon_pulse),
    .xoff_pulse(xoff_pulse)
);

// File: tb/rx_spchr_detect_test.sv
`timescale 1ns/1ps
module rx_spchr_detect_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic [7:0] key_on1, key_on2, key_off1, key_off2;
    logic       det_en, gpio_qual, swfc_en;
    logic [1:0] key_sel;
    logic [3:0] gpio_in;
    logic       irq_clr;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       irq_flag, xon_pulse, xoff_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_spchr_detect uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .key_on1(key_on1), .key_on2(key_on2), .key_off1(key_off1), .key_off2(key_off2),
        .det_en(det_en), .gpio_qual(gpio_qual), .swfc_en(swfc_en), .key_sel(key_sel),
        .gpio_in(gpio_in), .irq_clr(irq_clr), .out_valid(out_valid), .out_byte(out_byte),
        .irq_flag(irq_flag), .xon_pulse(xon_pulse), .xoff_pulse(xoff_pulse)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h time=%0t", req, got, exp, $time);
        end
    endtask

    function automatic logic key_hit(input logic [7:0] b, input logic [7:0] k,
                                     input logic q, input logic [3:0] g);
        if (q) return (g == k[7:4]) && (b[3:0] == k[3:0]);
        return b == k;
    endfunction

    task automatic drive(input logic v, input logic [7:0] b, input logic clr);
        @(negedge clk);
        in_valid = v;
        in_byte  = b;
        irq_clr  = clr;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 1; in_byte = 8'h11; irq_clr = 0;
        key_on1 = 8'h11; key_on2 = 8'h13; key_off1 = 8'h93; key_off2 = 8'hA5;
        det_en = 1; gpio_qual = 0; swfc_en = 1; key_sel = 2'b11; gpio_in = 4'h1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check({7'd0, out_valid}, 8'd0, "R1 out_valid");
        check({7'd0, irq_flag}, 8'd0, "R1 irq_flag");
        check({6'd0, xon_pulse, xoff_pulse}, 8'd0, "R1 pulses");
        @(negedge clk);
        rst = 0; in_valid = 0;

        // Sweep: R2 R3 R4 R5 R6 R7 R8 R10 R11 with irq_clr high on every byte
        for (int cfg = 0; cfg < 32; cfg++) begin
            @(negedge clk);
            key_sel   = cfg[1:0];
            swfc_en   = cfg[2];
            gpio_qual = cfg[3];
            det_en    = cfg[4];
            for (int bi = 0; bi < 256; bi++) begin
                logic [7:0] b;
                logic       v;
                logic [3:0] g;
                logic       m;
                b = bi[7:0];
                v = (bi % 7) != 3;
                g = b[3:0] ^ b[7:4];
                gpio_in = g;
                m = 0;
                if (key_sel[0] && !swfc_en && key_hit(b, key_on1, gpio_qual, g)) m = 1;
                if (key_sel[0] && key_hit(b, key_on2, gpio_qual, g)) m = 1;
                if (key_sel[1] && !swfc_en && key_hit(b, key_off1, gpio_qual, g)) m = 1;
                if (key_sel[1] && key_hit(b, key_off2, gpio_qual, g)) m = 1;
                m = m && v && det_en;
                drive(v, b, 1'b1);
                check({7'd0, out_valid}, {7'd0, v}, "R2 out_valid");
                if (v) check(out_byte, b, "R2 out_byte");
                check({7'd0, irq_flag}, {7'd0, m}, "R4 R5 R6 R7 R3 R10 irq_flag");
                check({7'd0, xon_pulse}, {7'd0, v && swfc_en && b == key_on1}, "R8 xon_pulse");
                check({7'd0, xoff_pulse}, {7'd0, v && swfc_en && b == key_off1}, "R8 xoff_pulse");
            end
        end

        // R9: sticky flag then clear
        @(negedge clk);
        det_en = 1; gpio_qual = 0; swfc_en = 0; key_sel = 2'b11;
        drive(1'b1, 8'hA5, 1'b0);
        check({7'd0, irq_flag}, 8'd1, "R9 set");
        for (int i = 0; i < 5; i++) begin
            drive(i[0], 8'h00, 1'b0);
            check({7'd0, irq_flag}, 8'd1, "R9 held");
        end
        drive(1'b0, 8'h00, 1'b1);
        check({7'd0, irq_flag}, 8'd0, "R9 cleared");
        // R10: match with clear in same cycle after being set
        drive(1'b1, 8'h13, 1'b0);
        drive(1'b1, 8'h93, 1'b1);
        check({7'd0, irq_flag}, 8'd1, "R10 match wins");
        drive(1'b0, 8'h00, 1'b1);
        check({7'd0, irq_flag}, 8'd0, "R9 cleared again");
        // R11: strobe low with a matching byte and flow keys
        @(negedge clk);
        swfc_en = 1;
        drive(1'b0, 8'hA5, 1'b0);
        check({7'd0, irq_flag}, 8'd0, "R11 no flag");
        drive(1'b0, 8'h11, 1'b0);
        check({6'd0, xon_pulse, xoff_pulse}, 8'd0, "R11 no pulse");
        // R8: pulse lasts one cycle and ignores det_en and key_sel
        @(negedge clk);
        det_en = 0; key_sel = 2'b00; gpio_qual = 1; gpio_in = 4'h0;
        drive(1'b1, 8'h93, 1'b0);
        check({6'd0, xon_pulse, xoff_pulse}, 8'd1, "R8 xoff with det off");
        drive(1'b0, 8'h93, 1'b0);
        check({6'd0, xon_pulse, xoff_pulse}, 8'd0, "R8 single cycle");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule